// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block keeps the word address for a synchronous burst memory port. A burst starts when an external 16-bit address is captured through one of two start strobes. One strobe comes from the processor side and only counts while the chip is selected. The other comes from the memory controller side and always counts. After the start, each cycle with the advance strobe high moves the two low address bits one beat through a four-word block. The upper bits keep the value that was captured.

An order input selects the beat sequence. A value of 1 selects linear order: the low bits count upward and wrap inside the block. A value of 0 selects interleaved order: the starting low bits are XORed with the beat number. The order is captured at the start of a burst. Any start strobe captures a fresh address, so a new address can be loaded on every cycle with no lost cycles. All inputs are sampled on the rising clock edge, and the address output comes from a register.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst` is high at a rising edge, `addr_q` becomes 0 and the captured order becomes interleaved (0).
- R2: If `start_ctl` is high at an edge, `addr_q` equals `ext_addr` after that edge. This holds whatever the values of `chip_sel`, `start_cpu` and `adv`.
- R3: If `start_cpu` is high, `chip_sel` is high and `start_ctl` is low at an edge, `addr_q` equals `ext_addr` after that edge.
- R4: If `start_cpu` is high while `chip_sel` is low, the strobe is ignored. With `start_ctl` low, `addr_q` then either holds or advances exactly as if `start_cpu` were low.
- R5: With no accepted start strobe and `adv` low, `addr_q` keeps its value.
- R6: Without a start strobe, `addr_q[15:2]` never changes, including when the low bits wrap.
- R7: When `order_lin` is 1 at the start, beat n (the start is beat 0) has low bits equal to (start + n) mod 4. For example, a start of 1 gives 1,2,3,0.
- R8: When `order_lin` is 0 at the start, beat n has low bits equal to start XOR (n mod 4). For example, a start of 1 gives 1,0,3,2, and a start of 2 gives 2,3,0,1.
- R9: `order_lin` is only used when a burst starts. Changing it during a burst does not change the sequence.
- R10: A start strobe takes precedence over `adv` in the same cycle. Back-to-back starts load each new address, and each one restarts the beat count at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| ext_addr | input | 16 | External start address |
| start_cpu | input | 1 | Processor-side start strobe, only accepted when `chip_sel` is high |
| start_ctl | input | 1 | Controller-side start strobe, has priority and is always accepted |
| chip_sel | input | 1 | Chip selected |
| adv | input | 1 | Advance the burst by one beat |
| order_lin | input | 1 | 1 = linear order, 0 = interleaved order |
| addr_q | output | 16 | Current word address |

## Verification
The assertions check on every cycle the behaviour that can be seen at the ports alone:
- loading from either strobe, including the priority of the controller strobe and the gating of the processor strobe by select;
- holding the address when nothing happens;
- keeping the upper bits fixed.

The actual beat sequences need more than the ports show on one cycle. Linear and interleaved order from several start values, the wrap after four beats, and the capture of the order at the start all depend on state set at burst start. These are shown only by the bench scenarios, which compare every output against a reference model.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;
  typedef enum logic {ORD_ILV = 1'b0, ORD_LIN = 1'b1} order_e;
  typedef enum logic [1:0] {SRC_NONE, SRC_CTL, SRC_CPU} src_e;
endpackage

// File: rtl/burst_start_arb.sv
module burst_start_arb
  import burst_addr_pkg::*;
(
  input  logic start_cpu,
  input  logic start_ctl,
  input  logic chip_sel,
  output src_e src,
  output logic load
);
  always_comb begin
    if (start_ctl)                  src = SRC_CTL;
    else if (start_cpu && chip_sel) src = SRC_CPU;
    else                            src = SRC_NONE;
  end
  assign load = (src != SRC_NONE);
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             adv,
  output logic [CNT_W-1:0] beat_nxt
);
  logic [CNT_W-1:0] beat_r;

  always_comb begin
    if (load)     beat_nxt = '0;
    else if (adv) beat_nxt = beat_r + 1'b1;
    else          beat_nxt = beat_r;
  end

  always_ff @(posedge clk) begin
    if (rst) beat_r <= '0;
    else     beat_r <= beat_nxt;
  end
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_addr_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic [CNT_W-1:0] base,
  input  logic [CNT_W-1:0] beat,
  input  order_e           order,
  output logic [CNT_W-1:0] low
);
  logic [CNT_W-1:0] lin_low;
  logic [CNT_W-1:0] ilv_low;

  assign lin_low = base + beat;

  for (genvar i = 0; i < CNT_W; i++) begin : g_ilv
    assign ilv_low[i] = base[i] ^ beat[i];
  end

  assign low = (order == ORD_LIN) ? lin_low : ilv_low;
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic              start_cpu,
  input  logic              start_ctl,
  input  logic              chip_sel,
  input  logic              adv,
  input  logic              order_lin,
  output logic [ADDR_W-1:0] addr_q
);
  localparam int HI_W = ADDR_W - CNT_W;

  src_e             src;
  logic             load;
  logic [CNT_W-1:0] beat_nxt;
  logic [CNT_W-1:0] base_r, base_nxt;
  logic [HI_W-1:0]  hi_r, hi_nxt;
  order_e           ord_r, ord_nxt;
  logic [CNT_W-1:0] low_nxt;

  burst_start_arb u_arb (
    .start_cpu(start_cpu),
    .start_ctl(start_ctl),
    .chip_sel (chip_sel),
    .src      (src),
    .load     (load)
  );

  burst_beat_ctr #(.CNT_W(CNT_W)) u_beat (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .adv     (adv),
    .beat_nxt(beat_nxt)
  );

  always_comb begin
    if (load) begin
      base_nxt = ext_addr[CNT_W-1:0];
      hi_nxt   = ext_addr[ADDR_W-1:CNT_W];
      ord_nxt  = order_lin ? ORD_LIN : ORD_ILV;
    end else begin
      base_nxt = base_r;
      hi_nxt   = hi_r;
      ord_nxt  = ord_r;
    end
  end

  burst_order_map #(.CNT_W(CNT_W)) u_map (
    .base (base_nxt),
    .beat (beat_nxt),
    .order(ord_nxt),
    .low  (low_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      base_r <= '0;
      hi_r   <= '0;
      ord_r  <= ORD_ILV;
      addr_q <= '0;
    end else begin
      base_r <= base_nxt;
      hi_r   <= hi_nxt;
      ord_r  <= ord_nxt;
      addr_q <= {hi_nxt, low_nxt};
    end
  end
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] ext_addr,
  input logic              start_cpu,
  input logic              start_ctl,
  input logic              chip_sel,
  input logic              adv,
  input logic [ADDR_W-1:0] addr_q
);
  logic any_start;
  assign any_start = start_ctl || (start_cpu && chip_sel);

  // R1
  rst_clear_chk: assert property (@(posedge clk) rst |=> addr_q == '0);

  // R2
  ctl_load_chk: assert property (@(posedge clk) disable iff (rst)
    start_ctl |=> addr_q == $past(ext_addr));

  // R3
  cpu_load_chk: assert property (@(posedge clk) disable iff (rst)
    (start_cpu && chip_sel && !start_ctl) |=> addr_q == $past(ext_addr));

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!any_start && !adv) |=> $stable(addr_q));

  // R6
  upper_fixed_chk: assert property (@(posedge clk) disable iff (rst)
    !any_start |=> addr_q[ADDR_W-1:CNT_W] == $past(addr_q[ADDR_W-1:CNT_W]));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .ext_addr(ext_addr), .start_cpu(start_cpu),
  .start_ctl(start_ctl), .chip_sel(chip_sel), .adv(adv), .addr_q(addr_q)
);

// File: tb/burst_addr_gen_tb.sv
module burst_addr_gen_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] ext_addr = '0;
  logic        start_cpu = 1'b0, start_ctl = 1'b0, chip_sel = 1'b0, adv = 1'b0, order_lin = 1'b0;
  logic [15:0] addr_q;

  int total = 0;
  int bad   = 0;

  typedef struct { logic [15:0] exp; string req; } item_t;
  item_t sb_q[$];

  // reference model state
  logic [15:0] m_start;
  logic [1:0]  m_beat;
  logic        m_lin;

  always #2.5 clk = ~clk;

  burst_addr_gen u_dut (
    .clk(clk), .rst(rst), .ext_addr(ext_addr), .start_cpu(start_cpu),
    .start_ctl(start_ctl), .chip_sel(chip_sel), .adv(adv),
    .order_lin(order_lin), .addr_q(addr_q)
  );

  function automatic logic [15:0] model_addr();
    logic [1:0] lo;
    lo = m_lin ? (m_start[1:0] + m_beat) : (m_start[1:0] ^ m_beat);
    return {m_start[15:2], lo};
  endfunction

  // drive one cycle at the falling edge, then push the address expected after the next rising edge
  task automatic step(input logic [15:0] a, input logic cpu, input logic ctl,
                      input logic sel, input logic ad, input logic lin, input string req);
    item_t it;
    @(negedge clk);
    ext_addr = a; start_cpu = cpu; start_ctl = ctl; chip_sel = sel; adv = ad; order_lin = lin;
    if (ctl || (cpu && sel)) begin
      m_start = a; m_beat = 2'd0; m_lin = lin;
    end else if (ad) begin
      m_beat = m_beat + 2'd1;
    end
    it.exp = model_addr();
    it.req = req;
    sb_q.push_back(it);
  endtask

  // monitor: compares away from the active edge
  always @(posedge clk) begin
    #1;
    if (!rst && sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      total++;
      if (addr_q !== it.exp) begin
        bad++;
        $display("FAIL %s: addr_q=%h expected=%h", it.req, addr_q, it.exp);
      end
    end
  end

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    m_start = '0; m_beat = '0; m_lin = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    total++;
    if (addr_q !== 16'h0) begin
      bad++; $display("FAIL R1: addr_q=%h expected=0000", addr_q);
    end
    @(negedge clk); rst = 1'b0;
    // R1: interleaved default after reset, advancing from 0 with xor order
    step(16'h0000, 0, 0, 0, 1, 1, "R1");
    step(16'h0000, 0, 0, 0, 1, 1, "R1");
    // R2/R7 linear start 1 with wrap
    step(16'h1231, 0, 1, 0, 0, 1, "R2");
    for (int i = 0; i < 5; i++) step(16'h0000, 0, 0, 0, 1, 0, "R7");
    // R5 hold
    step(16'h5555, 0, 0, 1, 0, 0, "R5");
    step(16'h5555, 0, 0, 0, 0, 1, "R5");
    // R3/R8 interleaved start 1 and 2
    step(16'hA0B1, 1, 0, 1, 0, 0, "R3");
    for (int i = 0; i < 4; i++) step(16'h0000, 0, 0, 0, 1, 1, "R8 R9");
    step(16'h4442, 1, 0, 1, 0, 0, "R3");
    for (int i = 0; i < 3; i++) step(16'h0000, 0, 0, 1, 1, 0, "R8");
    // R4 processor strobe while deselected
    step(16'hDEAD, 1, 0, 0, 0, 1, "R4");
    step(16'hBEEF, 1, 0, 0, 1, 1, "R4");
    // R2 controller strobe with select low and both strobes
    step(16'h7777, 1, 1, 0, 1, 1, "R2");
    step(16'h3338, 1, 1, 1, 1, 0, "R2");
    // R6 upper bits fixed across wrap
    step(16'hFFFF, 0, 1, 0, 0, 1, "R6");
    for (int i = 0; i < 4; i++) step(16'h0000, 0, 0, 0, 1, 0, "R6");
    // R10 back-to-back loads with adv high
    for (int i = 0; i < 6; i++)
      step(16'(16'h1000 + i * 16'h0123), (i % 2) == 0, (i % 2) == 1, 1, 1, i[0], "R10");
    step(16'h0000, 0, 0, 0, 1, 0, "R10");
    @(negedge clk); start_cpu = 0; start_ctl = 0; adv = 0;
    repeat (3) @(posedge clk);
    #2;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule